// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a single progressive video output. A pixel counter and a line counter run from programmed totals; around them the block derives an active-video window and four independent sync-output sets. Each set has its own horizontal pulse and its own vertical pulse, so every downstream encoder can be given sync edges shifted to cancel its own pipeline latency.

Configuration arrives over a simple word-addressed write port. Writes land in a shadow bank and are copied to the working bank only when the raster restarts. That happens at the natural end of a frame, on a restart command, or on a slave sync edge, so a frame is never rendered with mixed settings. The horizontal origin (pixel 0) and vertical origin (line 1) sit at the start of the sync interval, not at the start of active video. The vertical total is programmed in half-lines. In slave mode a rising edge on an external sync input realigns the counters to the origin. A single-cycle top-field event marks the first pixel of every frame.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel counter counts 0 to L-1 and then returns to 0, where L is the low 16 bits of word 1. `o_pix` shows the pixel coordinate of each output cycle.
- R2: Lines are numbered from 1 to H/2, where H is the low 16 bits of word 2 (half-lines per field). The line advances when the pixel counter wraps, and returns to 1 after line H/2. `o_line` changes only together with pixel 0.
- R3: `o_de` is high when the line lies between the high halves of word 4 (start) and word 5 (stop), inclusive, and the pixel lies between their low halves, inclusive.
- R4: For set k, word 16+4k holds the falling-edge pixel in bits [31:16] and the rising-edge pixel in bits [15:0]. `o_hs[k]` is high when rise <= pixel < fall.
- R5: For set k, word 17+4k holds the end line [31:16] and start line [15:0], and word 18+4k holds the end pixel [31:16] and start pixel [15:0]. `o_vs[k]` is high from position (start line, start pixel) inclusive up to (end line, end pixel) exclusive, in raster order.
- R6: The four sync sets are independent. Each output follows only its own three words.
- R7: Writes to words other than word 3 go to a shadow copy. The outputs use them only after the next frame wrap or restart, so a frame in progress keeps its old settings.
- R8: Writing word 3 with bit 0 = 1 restarts the counters. Two cycles after the write cycle the outputs show pixel 0, line 1. Writing bit 0 = 0 has no effect.
- R9: Bit 0 of word 0 selects the mode: 0 is master, where `ext_sync` is ignored; 1 is slave, where a rising edge of `ext_sync` restarts the counters, visible at the outputs two cycles later. A held level does not restart them again.
- R10: `o_top_evt` pulses high for exactly the output cycle that shows pixel 0 of line 1.
- R11: All outputs are registered. While `rst` is high they are 0. The first cycle after reset shows pixel 0, line 1, with `o_top_evt` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| ext_sync | input | 1 | External sync input used in slave mode |
| o_pix | output | 16 | Pixel coordinate of the current output cycle |
| o_line | output | 16 | Line coordinate of the current output cycle |
| o_de | output | 1 | Active-video window |
| o_hs | output | NSETS | Horizontal sync, one per set |
| o_vs | output | NSETS | Vertical sync, one per set |
| o_top_evt | output | 1 | Frame-start (top field) event |

## Verification
The hardest case to reach from the ports is a configuration write that lands in the middle of a frame. To prove it is deferred, the bench must show that the running frame still wraps at the old line length and that the new length appears only after the frame boundary. The bench gets there by keeping its own model of position and of the shadow and working banks, which it advances on every clock. It times a line-length write to land mid-line and measures the largest pixel index seen before and after the next frame start. Slave alignment is the second hard case. The bench enables slave mode, waits for it to take hold at a frame boundary, then holds `ext_sync` high over several cycles to show that only the edge restarts the raster.

// File: rtl/rtg_pkg.sv
`timescale 1ns/1ps
package rtg_pkg;
  localparam int unsigned FIELD_W = 16;

  // word addresses
  localparam int unsigned ADDR_MODE       = 0;
  localparam int unsigned ADDR_LINE_LEN   = 1;
  localparam int unsigned ADDR_HALF_LINES = 2;
  localparam int unsigned ADDR_RESTART    = 3;
  localparam int unsigned ADDR_WIN_START  = 4;
  localparam int unsigned ADDR_WIN_STOP   = 5;
  localparam int unsigned ADDR_SET_BASE   = 16;
  localparam int unsigned SET_STRIDE      = 4;
  localparam int unsigned SET_H           = 0;
  localparam int unsigned SET_VLINE       = 1;
  localparam int unsigned SET_VPIX        = 2;

  typedef struct packed {
    logic [FIELD_W-1:0] hi;
    logic [FIELD_W-1:0] lo;
  } pair_t;
endpackage

// File: rtl/rtg_regs.sv
`timescale 1ns/1ps
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int unsigned NSETS          = 4,
  parameter int unsigned ADDR_W         = 6,
  parameter int unsigned DEF_LINE_LEN   = 800,
  parameter int unsigned DEF_HALF_LINES = 1050,
  localparam int unsigned NREG  = ADDR_SET_BASE + SET_STRIDE * NSETS,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  pair_t             wdata,
  input  logic              load,
  output pair_t             act_o [NREG],
  output logic              restart_cmd
);

  pair_t sh_q  [NREG];
  pair_t act_q [NREG];

  function automatic pair_t def_word(int unsigned idx);
    pair_t w;
    w = '0;
    if (idx == ADDR_LINE_LEN)   w.lo = FIELD_W'(DEF_LINE_LEN);
    if (idx == ADDR_HALF_LINES) w.lo = FIELD_W'(DEF_HALF_LINES);
    return w;
  endfunction

  logic in_range;
  logic is_restart;
  assign in_range    = addr < ADDR_W'(NREG);
  assign is_restart  = addr == ADDR_W'(ADDR_RESTART);
  assign restart_cmd = we && is_restart && wdata.lo[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        sh_q[i]  <= def_word(i);
        act_q[i] <= def_word(i);
      end
    end else begin
      if (we && in_range && !is_restart)
        sh_q[addr[IDX_W-1:0]] <= wdata;
      if (load)
        for (int i = 0; i < NREG; i++) act_q[i] <= sh_q[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) act_o[i] = act_q[i];
  end

endmodule

// File: rtl/rtg_counter.sv
`timescale 1ns/1ps
module rtg_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] line_len,
  input  logic [CNT_W-1:0] frame_lines,
  output logic [CNT_W-1:0] pix,
  output logic [CNT_W-1:0] line,
  output logic             eof
);

  logic [CNT_W:0] pix_nx;
  logic           eol;

  assign pix_nx = {1'b0, pix} + {{CNT_W{1'b0}}, 1'b1};
  assign eol    = pix_nx >= {1'b0, line_len};
  assign eof    = eol && (line >= frame_lines);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pix  <= '0;
      line <= CNT_W'(1);
    end else if (eol) begin
      pix  <= '0;
      line <= (line >= frame_lines) ? CNT_W'(1) : line + CNT_W'(1);
    end else begin
      pix  <= pix_nx[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/rtg_window.sv
`timescale 1ns/1ps
module rtg_window
  import rtg_pkg::*;
(
  input  logic [FIELD_W-1:0] pix,
  input  logic [FIELD_W-1:0] line,
  input  pair_t              first,
  input  pair_t              last,
  output logic               de
);

  logic in_rows;
  logic in_cols;
  assign in_rows = (line >= first.hi) && (line <= last.hi);
  assign in_cols = (pix  >= first.lo) && (pix  <= last.lo);
  assign de      = in_rows && in_cols;

endmodule

// File: rtl/rtg_sync_set.sv
`timescale 1ns/1ps
module rtg_sync_set
  import rtg_pkg::*;
(
  input  logic [FIELD_W-1:0] pix,
  input  logic [FIELD_W-1:0] line,
  input  pair_t              hword,
  input  pair_t              vline,
  input  pair_t              vpix,
  output logic               hs,
  output logic               vs
);

  logic [2*FIELD_W-1:0] pos;
  logic [2*FIELD_W-1:0] v_on;
  logic [2*FIELD_W-1:0] v_off;

  assign pos   = {line, pix};
  assign v_on  = {vline.lo, vpix.lo};
  assign v_off = {vline.hi, vpix.hi};

  assign hs = (pix >= hword.lo) && (pix < hword.hi);
  assign vs = (pos >= v_on) && (pos < v_off);

endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned NSETS          = 4,
  parameter int unsigned ADDR_W         = 6,
  parameter int unsigned DEF_LINE_LEN   = 800,
  parameter int unsigned DEF_HALF_LINES = 1050
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              ext_sync,
  output logic [15:0]       o_pix,
  output logic [15:0]       o_line,
  output logic              o_de,
  output logic [NSETS-1:0]  o_hs,
  output logic [NSETS-1:0]  o_vs,
  output logic              o_top_evt
);

  localparam int unsigned CNT_W = FIELD_W;
  localparam int unsigned NREG  = ADDR_SET_BASE + SET_STRIDE * NSETS;

  pair_t            wdata_w;
  pair_t            act [NREG];
  logic             restart_cmd;
  logic             sync_q;
  logic             mode_slave;
  logic             sync_restart;
  logic             restart;
  logic             eof;
  logic             load;
  logic [CNT_W-1:0] pix;
  logic [CNT_W-1:0] line;
  logic [CNT_W-1:0] frame_lines;
  logic             de_c;
  logic [NSETS-1:0] hs_c;
  logic [NSETS-1:0] vs_c;

  assign wdata_w = cfg_wdata;

  rtg_regs #(
    .NSETS(NSETS), .ADDR_W(ADDR_W),
    .DEF_LINE_LEN(DEF_LINE_LEN), .DEF_HALF_LINES(DEF_HALF_LINES)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(wdata_w),
    .load(load), .act_o(act), .restart_cmd(restart_cmd)
  );

  assign mode_slave   = act[ADDR_MODE].lo[0];
  assign sync_restart = mode_slave && ext_sync && !sync_q;
  assign restart      = restart_cmd || sync_restart;
  assign load         = restart || eof;
  assign frame_lines  = {1'b0, act[ADDR_HALF_LINES].lo[CNT_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b0;
    else     sync_q <= ext_sync;
  end

  rtg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart),
    .line_len(act[ADDR_LINE_LEN].lo), .frame_lines(frame_lines),
    .pix(pix), .line(line), .eof(eof)
  );

  rtg_window u_win (
    .pix(pix), .line(line),
    .first(act[ADDR_WIN_START]), .last(act[ADDR_WIN_STOP]), .de(de_c)
  );

  for (genvar k = 0; k < NSETS; k++) begin : g_set
    rtg_sync_set u_set (
      .pix(pix), .line(line),
      .hword(act[ADDR_SET_BASE + SET_STRIDE * k + SET_H]),
      .vline(act[ADDR_SET_BASE + SET_STRIDE * k + SET_VLINE]),
      .vpix (act[ADDR_SET_BASE + SET_STRIDE * k + SET_VPIX]),
      .hs(hs_c[k]), .vs(vs_c[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_pix     <= '0;
      o_line    <= '0;
      o_de      <= 1'b0;
      o_hs      <= '0;
      o_vs      <= '0;
      o_top_evt <= 1'b0;
    end else begin
      o_pix     <= pix;
      o_line    <= line;
      o_de      <= de_c;
      o_hs      <= hs_c;
      o_vs      <= vs_c;
      o_top_evt <= (pix == '0) && (line == CNT_W'(1));
    end
  end

endmodule

// File: rtl/rtg_chk.sv
`timescale 1ns/1ps
module rtg_chk
  import rtg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic              ext_sync,
  input logic              mode_slave,
  input logic              sync_q,
  input logic [15:0]       o_pix,
  input logic [15:0]       o_line,
  input logic              o_top_evt
);

  // R1
  pix_step_chk: assert property (@(posedge clk) disable iff (rst)
    (o_pix != 16'd0) |-> (o_pix == $past(o_pix) + 16'd1));

  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    (o_line != $past(o_line)) |-> (o_pix == 16'd0));

  // R10
  top_pos_chk: assert property (@(posedge clk) disable iff (rst)
    o_top_evt |-> (o_pix == 16'd0 && o_line == 16'd1));

  // R8
  restart_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == ADDR_W'(ADDR_RESTART) && cfg_wdata[0]) |-> ##2 o_top_evt);

  // R9
  slave_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_slave && ext_sync && !sync_q) |-> ##2 o_top_evt);

endmodule

bind raster_timing_gen rtg_chk #(.ADDR_W(ADDR_W)) u_rtg_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .ext_sync(ext_sync), .mode_slave(mode_slave),
  .sync_q(sync_q), .o_pix(o_pix), .o_line(o_line), .o_top_evt(o_top_evt)
);

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
  localparam int NSETS  = 4;
  localparam int ADDR_W = 6;
  localparam int NREG   = 16 + 4 * NSETS;
  localparam int DLL    = 10;
  localparam int DHL    = 12;

  // per vector: line_len, lines, wsp, wsl, wep, wel, hrise, hfall, vls, vle, vps, vpe
  localparam logic [7:0] VEC [3][12] = '{
    '{8'd10, 8'd6, 8'd3, 8'd2, 8'd8,  8'd5, 8'd0, 8'd2, 8'd1, 8'd2, 8'd0, 8'd0},
    '{8'd12, 8'd5, 8'd4, 8'd3, 8'd11, 8'd5, 8'd5, 8'd8, 8'd1, 8'd3, 8'd5, 8'd5},
    '{8'd7,  8'd4, 8'd0, 8'd1, 8'd6,  8'd4, 8'd2, 8'd6, 8'd2, 8'd4, 8'd3, 8'd1}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic              ext_sync = 1'b0;
  logic [15:0]       o_pix;
  logic [15:0]       o_line;
  logic              o_de;
  logic [NSETS-1:0]  o_hs;
  logic [NSETS-1:0]  o_vs;
  logic              o_top_evt;

  always #2.5 clk = ~clk;

  raster_timing_gen #(
    .NSETS(NSETS), .ADDR_W(ADDR_W), .DEF_LINE_LEN(DLL), .DEF_HALF_LINES(DHL)
  ) u_raster_timing_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_sync(ext_sync), .o_pix(o_pix), .o_line(o_line),
    .o_de(o_de), .o_hs(o_hs), .o_vs(o_vs), .o_top_evt(o_top_evt)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  logic [31:0] sh [NREG];
  logic [31:0] ac [NREG];
  int c_pix, c_line;
  bit sprev;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock: model predicts outputs from requirements, then compares
  task automatic step();
    int px, ln, ll, fl;
    bit eol, eof, rs, e_de, e_top;
    bit [NSETS-1:0] e_hs, e_vs;
    px = c_pix; ln = c_line;
    ll = int'(ac[1][15:0]);
    fl = int'(ac[2][15:1]);
    e_de = ln >= int'(ac[4][31:16]) && ln <= int'(ac[5][31:16]) &&
           px >= int'(ac[4][15:0])  && px <= int'(ac[5][15:0]);
    for (int k = 0; k < NSETS; k++) begin
      logic [31:0] pos, von, voff;
      pos  = {16'(ln), 16'(px)};
      von  = {ac[17+4*k][15:0],  ac[18+4*k][15:0]};
      voff = {ac[17+4*k][31:16], ac[18+4*k][31:16]};
      e_hs[k] = px >= int'(ac[16+4*k][15:0]) && px < int'(ac[16+4*k][31:16]);
      e_vs[k] = pos >= von && pos < voff;
    end
    e_top = (px == 0) && (ln == 1);
    eol = (px + 1) >= ll;
    eof = eol && (ln >= fl);
    rs  = (cfg_we && int'(cfg_addr) == 3 && cfg_wdata[0]) ||
          (ac[0][0] && ext_sync && !sprev);
    @(posedge clk);
    if (rs || eof) begin
      c_pix = 0; c_line = 1;
      for (int i = 0; i < NREG; i++) ac[i] = sh[i];
    end else if (eol) begin
      c_pix = 0; c_line = ln + 1;
    end else begin
      c_pix = px + 1;
    end
    sprev = ext_sync;
    if (cfg_we && int'(cfg_addr) != 3 && int'(cfg_addr) < NREG)
      sh[cfg_addr[4:0]] = cfg_wdata;
    @(negedge clk);
    chk("R1", "pixel", int'(o_pix), px);
    chk("R2", "line", int'(o_line), ln);
    chk("R3", "de", int'(o_de), int'(e_de));
    chk("R4 R6", "hsync", int'(o_hs), int'(e_hs));
    chk("R5 R6", "vsync", int'(o_vs), int'(e_vs));
    chk("R10", "top event", int'(o_top_evt), int'(e_top));
  endtask

  task automatic wr(int a, int hi, int lo);
    cfg_addr  = ADDR_W'(a);
    cfg_wdata = {16'(hi), 16'(lo)};
    cfg_we    = 1'b1;
    step();
    cfg_we    = 1'b0;
  endtask

  task automatic program_vec(int v);
    wr(1, 0, int'(VEC[v][0]));
    wr(2, 0, 2 * int'(VEC[v][1]));
    wr(4, int'(VEC[v][3]), int'(VEC[v][2]));
    wr(5, int'(VEC[v][5]), int'(VEC[v][4]));
    // R6: each set gets its own offsets
    for (int k = 0; k < NSETS; k++) begin
      wr(16 + 4*k, int'(VEC[v][7]) + k, int'(VEC[v][6]) + k);
      wr(17 + 4*k, int'(VEC[v][9]), int'(VEC[v][8]));
      wr(18 + 4*k, int'(VEC[v][11]) + k, int'(VEC[v][10]));
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int mx, guard;
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11", "reset pixel", int'(o_pix), 0);
    chk("R11", "reset line", int'(o_line), 0);
    chk("R11", "reset de", int'(o_de), 0);
    chk("R11", "reset hs", int'(o_hs), 0);
    chk("R11", "reset vs", int'(o_vs), 0);
    chk("R11", "reset top", int'(o_top_evt), 0);
    for (int i = 0; i < NREG; i++) sh[i] = '0;
    sh[1] = 32'(DLL); sh[2] = 32'(DHL);
    for (int i = 0; i < NREG; i++) ac[i] = sh[i];
    c_pix = 0; c_line = 1; sprev = 1'b0;
    rst = 1'b0;
    step();
    chk("R11", "first top after reset", int'(o_top_evt), 1);

    // vector table walk: program, restart, run two frames
    for (int v = 0; v < 3; v++) begin
      program_vec(v);
      wr(3, 0, 1);
      repeat (2 * int'(VEC[v][0]) * int'(VEC[v][1]) + 3) step();
    end

    // R8: restart command
    wr(3, 0, 1);
    step();
    chk("R8", "restart pixel", int'(o_pix), 0);
    chk("R8", "restart line", int'(o_line), 1);
    chk("R8", "restart top", int'(o_top_evt), 1);
    step(); step();
    wr(3, 0, 0);
    step();
    chk("R8", "bit0 clear ignored pixel", int'(o_pix), 4);
    chk("R8", "bit0 clear ignored line", int'(o_line), 1);

    // R9: master ignores ext_sync
    wr(3, 0, 1);
    step();
    ext_sync = 1'b1;
    step(); step();
    ext_sync = 1'b0;
    step();
    chk("R9", "master ignores sync pixel", int'(o_pix), 3);
    chk("R9", "master ignores sync top", int'(o_top_evt), 0);

    // R7: line length written mid-frame applies after the frame ends
    wr(1, 0, 9);
    mx = int'(o_pix); guard = 0;
    while (o_pix != 16'd0 && guard < 50) begin
      if (int'(o_pix) > mx) mx = int'(o_pix);
      step(); guard++;
    end
    chk("R7", "old length within frame", mx, 6);
    guard = 0;
    while (!o_top_evt && guard < 100) begin step(); guard++; end
    step();
    mx = 0; guard = 0;
    while (o_pix != 16'd0 && guard < 50) begin
      if (int'(o_pix) > mx) mx = int'(o_pix);
      step(); guard++;
    end
    chk("R7", "new length after frame", mx, 8);

    // R9: slave mode, edge restarts, held level does not
    wr(0, 0, 1);
    guard = 0;
    while (!o_top_evt && guard < 200) begin step(); guard++; end
    step(); step(); step();
    ext_sync = 1'b1;
    step(); step();
    chk("R9", "slave sync pixel", int'(o_pix), 0);
    chk("R9", "slave sync line", int'(o_line), 1);
    chk("R9", "slave sync top", int'(o_top_evt), 1);
    step(); step();
    chk("R9", "held sync no retrigger", int'(o_pix), 2);
    ext_sync = 1'b0;
    repeat (5) step();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule